// File: doc/BRIEF.md
# Decimal Field Multiplier

This unit multiplies two unsigned decimal numbers that sit as digit strings in its own small digit memory. Every memory location holds one BCD digit. An operand is described by the address of its most significant digit and its length in digits. A start command captures both operand descriptors. The unit then forms the product in place. The product field begins at the first operand-B address and is as long as the two operand lengths added together. It replaces B and the locations that follow B. Because the field is that long, every product fits and there is no overflow case.

Internally the unit first copies the B digits into a private multiplier buffer, so it can overwrite the B field freely. It then clears the product field. It works through the multiplier digits from least to most significant. For each one it walks the A digits from least to most significant and adds the digit product into the field with a decimal carry, shifting one position per multiplier digit. After each pass it ripples any leftover carry upward. The memory is loaded and read through a simple digit port while the unit is idle.

Top module: `dfm_top`

## Requirements
- R1: Every memory location holds one BCD digit (0 to 9). Numbers are stored most significant digit first at ascending addresses. Every digit the unit writes is in the range 0 to 9.
- R2: An accepted start captures `a_addr`, `a_len`, `b_addr` and `b_len`. Each length must lie between 1 and 10.
- R3: When the operation ends, addresses `b_addr` to `b_addr+a_len+b_len-1` hold A×B as `a_len+b_len` decimal digits, padded with leading zeros. The unit writes no location below `b_addr` and produces no overflow indication.
- R4: Every location outside the product field keeps its value, including the A field.
- R5: `busy` is high in the cycle after an accepted start, which is a start while `busy` is low. It stays high until the last product digit has been written.
- R6: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after an operation. It is never high while `busy` is high.
- R7: A start while `busy` is high is ignored. The running operation finishes with its original operands.
- R8: A memory write on `wr_en`/`wr_addr`/`wr_digit` takes effect at the clock edge while the unit is idle. It is ignored while `busy` is high, and the unit itself writes nothing while idle.
- R9: `rd_digit` shows the digit at `rd_addr` combinationally. Reset clears every location to 0 and drives `busy` and `done` low.
- R10: An all-zero operand gives an all-zero product. The largest operands, ten nines by ten nines, give the exact 20-digit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted when idle |
| a_addr | input | 6 | Address of the most significant digit of A |
| a_len | input | 4 | Digit count of A (1 to 10) |
| b_addr | input | 6 | Address of the most significant digit of B and of the product |
| b_len | input | 4 | Digit count of B (1 to 10) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Memory digit write enable (idle only) |
| wr_addr | input | 6 | Memory write address |
| wr_digit | input | 4 | Digit to write |
| rd_addr | input | 6 | Memory read address |
| rd_digit | output | 4 | Digit at rd_addr |

## Verification
The assertions assume that an accepted start carries lengths between 1 and 10. They also assume that the whole product field, from `b_addr` up to `b_addr+a_len+b_len-1`, fits inside the memory without wrapping. A further assumption is that the A field lies outside that product field, and that only BCD digits are ever loaded. The stimulus respects these limits. It places A in the low addresses 0 to 10 and B in the range 24 to 44, so a 20-digit product still ends inside the 64 locations. It writes only digits 0 to 9, and it draws both lengths from 1 to 10, covering every pairing of the two.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

    typedef logic [3:0] digit_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COPY,
        ST_CLEAR,
        ST_MUL,
        ST_CARRY
    } state_e;

    typedef struct packed {
        digit_t carry;
        digit_t sum;
    } mac_t;

    // p + a*d + c never exceeds 99, so both halves of the result are BCD
    function automatic mac_t digit_mac(digit_t p, digit_t a, digit_t d, digit_t c);
        logic [6:0] s;
        mac_t r;
        s       = 7'(p) + 7'(a) * 7'(d) + 7'(c);
        r.sum   = digit_t'(s % 7'd10);
        r.carry = digit_t'(s / 7'd10);
        return r;
    endfunction

endpackage

// File: rtl/dfm_digit_mem.sv
module dfm_digit_mem
    import dfm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  digit_t                  wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output digit_t [NRD-1:0]        rdata
);

    digit_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) cells[k] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = cells[raddr[g]];
    end

endmodule

// File: rtl/dfm_mac.sv
module dfm_mac
    import dfm_pkg::*;
(
    input  digit_t p,
    input  digit_t a,
    input  digit_t d,
    input  digit_t c,
    output mac_t   res
);

    always_comb res = digit_mac(p, a, d, c);

endmodule

// File: rtl/dfm_ctrl.sv
module dfm_ctrl
    import dfm_pkg::*;
#(
    parameter int AW      = 6,
    parameter int MAX_LEN = 10,
    localparam int LW     = $clog2(MAX_LEN + 1),
    localparam int PW     = $clog2(2 * MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] a_addr,
    input  logic [LW-1:0] a_len,
    input  logic [AW-1:0] b_addr,
    input  logic [LW-1:0] b_len,
    input  digit_t        rd_a,
    input  digit_t        rd_p,
    input  mac_t          mac_res,
    output logic [AW-1:0] ra_a,
    output logic [AW-1:0] ra_p,
    output digit_t        mac_p,
    output digit_t        mac_a,
    output digit_t        mac_d,
    output digit_t        mac_c,
    output logic          eng_we,
    output logic [AW-1:0] eng_addr,
    output digit_t        eng_wdata,
    output logic          busy,
    output logic          done
);

    state_e        st;
    logic [AW-1:0] a_base, b_base, pa;
    logic [LW-1:0] la, lb, i, j;
    logic [PW-1:0] cnt, plen;
    digit_t        carry;
    digit_t        mb [MAX_LEN];
    logic          done_q;

    assign plen = PW'(la) + PW'(lb);
    assign busy = (st != ST_IDLE);
    assign done = done_q;

    assign ra_a  = a_base + AW'(i);
    assign ra_p  = (st == ST_COPY) ? b_base + AW'(cnt) : pa;
    assign mac_p = rd_p;
    assign mac_a = (st == ST_MUL) ? rd_a : '0;
    assign mac_d = mb[j];
    assign mac_c = carry;

    always_comb begin
        eng_we    = (st == ST_CLEAR) || (st == ST_MUL) || (st == ST_CARRY && carry != '0);
        eng_addr  = (st == ST_CLEAR) ? b_base + AW'(cnt) : pa;
        eng_wdata = (st == ST_CLEAR) ? '0 : mac_res.sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            a_base <= '0;
            b_base <= '0;
            pa     <= '0;
            la     <= '0;
            lb     <= '0;
            i      <= '0;
            j      <= '0;
            cnt    <= '0;
            carry  <= '0;
            done_q <= 1'b0;
            for (int k = 0; k < MAX_LEN; k++) mb[k] <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    a_base <= a_addr;
                    b_base <= b_addr;
                    la     <= a_len;
                    lb     <= b_len;
                    cnt    <= '0;
                    st     <= ST_COPY;
                end
                ST_COPY: begin
                    mb[cnt[LW-1:0]] <= rd_p;
                    if (cnt == PW'(lb) - PW'(1)) begin
                        cnt <= '0;
                        st  <= ST_CLEAR;
                    end else begin
                        cnt <= cnt + PW'(1);
                    end
                end
                ST_CLEAR: begin
                    if (cnt == plen - PW'(1)) begin
                        j     <= lb - LW'(1);
                        i     <= la - LW'(1);
                        pa    <= b_base + AW'(plen) - AW'(1);
                        carry <= '0;
                        st    <= ST_MUL;
                    end else begin
                        cnt <= cnt + PW'(1);
                    end
                end
                ST_MUL: begin
                    carry <= mac_res.carry;
                    pa    <= pa - AW'(1);
                    if (i == '0) st <= ST_CARRY;
                    else         i  <= i - LW'(1);
                end
                ST_CARRY: begin
                    if (carry != '0) begin
                        carry <= mac_res.carry;
                        pa    <= pa - AW'(1);
                    end else if (j == '0) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        j  <= j - LW'(1);
                        i  <= la - LW'(1);
                        pa <= b_base + AW'(la) + AW'(j) - AW'(1);
                        st <= ST_MUL;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dfm_top.sv
module dfm_top
    import dfm_pkg::*;
#(
    parameter int MEM_DEPTH = 64,
    parameter int MAX_LEN   = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [$clog2(MEM_DEPTH)-1:0]  a_addr,
    input  logic [$clog2(MAX_LEN+1)-1:0]  a_len,
    input  logic [$clog2(MEM_DEPTH)-1:0]  b_addr,
    input  logic [$clog2(MAX_LEN+1)-1:0]  b_len,
    output logic                          busy,
    output logic                          done,
    input  logic                          wr_en,
    input  logic [$clog2(MEM_DEPTH)-1:0]  wr_addr,
    input  logic [3:0]                    wr_digit,
    input  logic [$clog2(MEM_DEPTH)-1:0]  rd_addr,
    output logic [3:0]                    rd_digit
);

    localparam int AW = $clog2(MEM_DEPTH);

    logic [AW-1:0]       ra_a, ra_p, eng_addr, mem_waddr;
    logic [2:0][AW-1:0]  raddr;
    digit_t [2:0]        rdata;
    digit_t              mac_p, mac_a, mac_d, mac_c, eng_wdata, mem_wdata;
    mac_t                mac_res;
    logic                eng_we, mem_we;

    assign mem_we    = busy ? eng_we    : wr_en;
    assign mem_waddr = busy ? eng_addr  : wr_addr;
    assign mem_wdata = busy ? eng_wdata : wr_digit;
    assign raddr     = {ra_p, ra_a, rd_addr};
    assign rd_digit  = rdata[0];

    dfm_digit_mem #(.DEPTH(MEM_DEPTH), .NRD(3)) u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(raddr), .rdata(rdata)
    );

    dfm_mac u_mac (
        .p(mac_p), .a(mac_a), .d(mac_d), .c(mac_c), .res(mac_res)
    );

    dfm_ctrl #(.AW(AW), .MAX_LEN(MAX_LEN)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .a_addr(a_addr), .a_len(a_len), .b_addr(b_addr), .b_len(b_len),
        .rd_a(rdata[1]), .rd_p(rdata[2]), .mac_res(mac_res),
        .ra_a(ra_a), .ra_p(ra_p),
        .mac_p(mac_p), .mac_a(mac_a), .mac_d(mac_d), .mac_c(mac_c),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .busy(busy), .done(done)
    );

endmodule

// File: rtl/dfm_checker.sv
module dfm_checker #(
    parameter int MEM_DEPTH = 64,
    parameter int MAX_LEN   = 10,
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int LW       = $clog2(MAX_LEN + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [LW-1:0] a_len,
    input logic [LW-1:0] b_len,
    input logic [AW-1:0] b_addr,
    input logic          eng_we,
    input logic [AW-1:0] eng_addr,
    input logic [3:0]    eng_wdata
);

    logic [AW-1:0] lo, hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else if (start && !busy) begin
            lo <= b_addr;
            hi <= b_addr + AW'(a_len) + AW'(b_len) - AW'(1);
        end
    end

    p_bcd_digit_r1: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> eng_wdata <= 4'd9);

    p_len_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> (a_len >= LW'(1) && a_len <= LW'(MAX_LEN)
                              && b_len >= LW'(1) && b_len <= LW'(MAX_LEN)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_we) |-> (eng_addr >= lo && eng_addr <= hi));

    p_busy_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_we);

endmodule

bind dfm_top dfm_checker #(.MEM_DEPTH(MEM_DEPTH), .MAX_LEN(MAX_LEN)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .a_len(a_len), .b_len(b_len), .b_addr(b_addr),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata)
);

// File: tb/sim_dfm_top.sv
module sim_dfm_top;

    logic       clk = 1'b0;
    logic       rst, start, wr_en, busy, done;
    logic [5:0] a_addr, b_addr, wr_addr, rd_addr;
    logic [3:0] a_len, b_len, wr_digit, rd_digit;

    int checks = 0;
    int fails  = 0;
    int sh [64];

    always #5 clk = ~clk;

    dfm_top u0 (
        .clk(clk), .rst(rst), .start(start),
        .a_addr(a_addr), .a_len(a_len), .b_addr(b_addr), .b_len(b_len),
        .busy(busy), .done(done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_digit(wr_digit),
        .rd_addr(rd_addr), .rd_digit(rd_digit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic poke(input int addr, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_digit = 4'(d);
        @(negedge clk);
        wr_en = 1'b0;
        sh[addr] = d;
    endtask

    // schoolbook model: digit convolution, then carry normalisation
    task automatic model(input int aa, input int al, input int ba, input int bl);
        int ad [10];
        int bd [10];
        int pr [21];
        int pl;
        pl = al + bl;
        for (int k = 0; k < 21; k++) pr[k] = 0;
        for (int k = 0; k < al; k++) ad[k] = sh[aa + al - 1 - k];
        for (int k = 0; k < bl; k++) bd[k] = sh[ba + bl - 1 - k];
        for (int x = 0; x < al; x++)
            for (int y = 0; y < bl; y++) pr[x + y] += ad[x] * bd[y];
        for (int k = 0; k < pl; k++) begin
            pr[k + 1] += pr[k] / 10;
            pr[k] = pr[k] % 10;
        end
        for (int k = 0; k < pl; k++) sh[ba + pl - 1 - k] = pr[k];
    endtask

    task automatic compare_all(input string req);
        int bad = -1;
        int act = 0;
        @(negedge clk);
        for (int k = 0; k < 64; k++) begin
            rd_addr = 6'(k);
            #0.1;
            if (bad < 0 && int'(rd_digit) != sh[k]) begin
                bad = k;
                act = int'(rd_digit);
            end
        end
        if (bad >= 0) check(1'b0, req, act, sh[bad]);
        else          check(1'b1, req, 0, 0);
    endtask

    task automatic run_op(input int aa, input int al, input int ba, input int bl,
                          input bit disturb, input string req);
        int cyc = 0;
        int keep;
        model(aa, al, ba, bl);
        @(negedge clk);
        start = 1'b1;
        a_addr = 6'(aa); a_len = 4'(al); b_addr = 6'(ba); b_len = 4'(bl);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R5 busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (3) @(negedge clk);
            keep = sh[62];
            start = 1'b1; a_addr = 6'd0; a_len = 4'd1; b_addr = 6'd50; b_len = 4'd1;
            wr_en = 1'b1; wr_addr = 6'd62; wr_digit = 4'((keep + 1) % 10);
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
        end
        while (done !== 1'b1 && cyc < 3000) begin
            if (cyc > 0) check(busy === 1'b1, "R5 busy held", int'(busy), 1);
            @(negedge clk);
            cyc++;
        end
        check(done === 1'b1, "R6 done seen", int'(done), 1);
        check(busy === 1'b0, "R6 busy low with done", int'(busy), 0);
        @(negedge clk);
        check(done === 1'b0, "R6 done one cycle", int'(done), 0);
        compare_all(req);
    endtask

    task automatic fill(input int base, input int len, input int val);
        for (int k = 0; k < len; k++)
            poke(base + k, (val < 0) ? int'($urandom_range(9)) : val);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; start = 1'b0; wr_en = 1'b0;
        a_addr = '0; b_addr = '0; a_len = '0; b_len = '0;
        wr_addr = '0; wr_digit = '0; rd_addr = 6'd5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R9 reset busy", int'(busy), 0);
        check(done === 1'b0, "R9 reset done", int'(done), 0);
        check(rd_digit === 4'd0, "R9 reset memory", int'(rd_digit), 0);
        for (int k = 0; k < 64; k++) sh[k] = 0;

        // R8 R9: idle writes and combinational read
        fill(0, 64, -1);
        compare_all("R8 R9 idle load");

        // R10 zeros and all nines, R1 single digit
        fill(0, 3, 0);  fill(30, 2, 7);
        run_op(0, 3, 30, 2, 1'b0, "R10 zero operand");
        fill(0, 10, 9); fill(24, 10, 9);
        run_op(0, 10, 24, 10, 1'b0, "R10 nines by nines");
        fill(5, 1, 9);  fill(40, 1, 9);
        run_op(5, 1, 40, 1, 1'b0, "R1 single digits");
        fill(2, 4, -1); poke(34, 0);
        run_op(2, 4, 34, 1, 1'b0, "R3 zero multiplier digit");

        // R2 R3 R4: every length pairing with random placement and digits
        for (int la = 1; la <= 10; la++) begin
            for (int lb = 1; lb <= 10; lb++) begin
                int aa, ba;
                aa = int'($urandom_range(10));
                ba = 24 + int'($urandom_range(20));
                fill(aa, la, -1);
                fill(ba, lb, -1);
                run_op(aa, la, ba, lb, 1'b0, "R2 R3 R4 length sweep");
            end
        end

        // R7 R8: start and memory write while busy are ignored
        fill(0, 10, -1); fill(24, 10, -1);
        run_op(0, 10, 24, 10, 1'b1, "R7 R8 ignored while busy");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule